// File: doc/BRIEF.md
# Input Period Timeout Detector

This block watches one asynchronous single-bit input and raises a timeout flag when too much time has passed since that input's last rising edge. The input is brought into the clock domain through a two-stage synchronizer, and rising edges are found on the synchronized copy. Every detected edge restarts a count of clock cycles. When that count reaches a programmable limit, the flag rises at once, without waiting for the next edge.

The flag then stays high until the next rising edge of the input clears it. If no edge ever arrives, the flag stays high indefinitely. The limit is given in clock cycles on an input port. A typical use is supervising a periodic strobe, such as a heartbeat or a tachometer pulse, and triggering a recovery action when that strobe slows down or stops.

Top module: `period_watchdog`

## Requirements
- R1: If the input rises every P clock cycles with P <= limit, the flag stays low.
- R2: Latency of the rising flag. Call E the first clock edge that samples the input high after it was low. If no further rising edge has been sampled by then, the flag is high in the cycle after clock edge E+2+limit. With P > limit, the flag therefore rises in every period.
- R3: The flag is low in the cycle after clock edge E'+2, where E' is the clock edge that samples the next rising edge of the input. This holds for any limit of 1 or more.
- R4: Once high, the flag stays high for as long as no new rising edge arrives. The internal count saturates and never wraps back below the limit.
- R5: After reset, the flag stays low until the first rising edge of the input has been seen, however long the input stays idle.
- R6: A synchronous reset, active high, forces the flag low in the cycle after the reset edge and clears all history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Asynchronous input that is monitored |
| limit | input | CNT_W | Maximum period in clock cycles |
| flag | output | 1 | Timeout flag, high while the period limit is exceeded |

## Verification
A count that is off by one shows at the ports as a flag that rises one cycle early or late. It also shows as a spurious one-cycle pulse when the period is exactly equal to the limit, or as a missing pulse when the period is one cycle longer than the limit. The sweep exposes either case within the first period of that limit. A counter that wraps instead of saturating drops the flag during a long idle stretch, within 2^CNT_W cycles. A lost armed state shows as a flag before the first edge, or as a flag that never rises.

// File: rtl/period_watchdog.sv
module period_watchdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic [CNT_W-1:0] limit,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       sync_q;
  logic             rise;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], sig_in};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (rise) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign flag = armed && (cnt >= limit);

  assert_clear_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    (rise && limit != '0 && !rst) |=> (!flag || limit != $past(limit)));

  assert_quiet_unarmed_R5: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !flag);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !rise) |=> cnt == CNT_MAX);

  assert_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
    (flag && !rise) |=> (flag || limit != $past(limit)));

  assert_reset_low_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !flag);
endmodule

// File: tb/sim_period_watchdog.sv
module sim_period_watchdog;
  localparam int W    = 6;
  localparam int MAXC = 63;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sig = 1'b0;
  logic [W-1:0] lim = 6'd1;
  logic         flag;

  int    total = 0, bad = 0, t = 0, e_last = -1, e_prev = -1;
  string phase = "R5";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  period_watchdog #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .sig_in(sig), .limit(lim), .flag(flag)
  );

  function automatic bit model(int tt);
    int e, c;
    if (e_last >= 0 && tt >= e_last + 2) e = e_last;
    else if (e_prev >= 0)                e = e_prev;
    else return 1'b0;
    c = tt - e - 2;
    if (c > MAXC) c = MAXC;
    return c >= int'(lim);
  endfunction

  task automatic check(bit exp, string tag);
    total++;
    if (flag !== exp) begin
      bad++;
      $display("FAIL %s t=%0d limit=%0d actual=%b expected=%b", tag, t, lim, flag, exp);
    end
  endtask

  task automatic cyc(bit v);
    string tag;
    @(negedge clk);
    tag = phase;
    if (e_last < 0 || (e_prev < 0 && t < e_last + 2)) tag = "R5";
    else if (e_prev >= 0 && t >= e_last && t <= e_last + 2) tag = "R3";
    check(model(t), tag);
    if (v && !sig) begin
      e_prev = e_last;
      e_last = t + 1;
    end
    sig = v;
    t++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sig = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(1'b0, "R6");
    end
    rst = 1'b0;
    t = 0;
    e_last = -1;
    e_prev = -1;
  endtask

  initial begin
    for (int l = 1; l <= 8; l++) begin
      lim = 6'(l);
      do_reset();
      phase = "R5";
      repeat (20) cyc(1'b0);
      for (int p = 2; p <= 12; p++) begin
        phase = (p <= l) ? "R1" : "R2";
        repeat (4) begin
          repeat (p / 2) cyc(1'b1);
          repeat (p - p / 2) cyc(1'b0);
        end
      end
      phase = "R4";
      repeat (80) cyc(1'b0);
    end
    do_reset();
    phase = "R5";
    repeat (100) cyc(1'b0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired t=%0d actual=hung expected=finished", t);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule